// File: doc/BRIEF.md
# UART Host Register Bank

This block is the host-side register file of a classic serial port controller. A host presents a 3-bit port offset with separate read and write strobes. Eight offsets carry twelve logical registers. A read and a write to the same offset can reach different registers. Offsets 0 and 1 can also be switched over to a 16-bit baud divisor by a bank-select bit, which is the top bit of the line-control byte.

The block stores the line-control, interrupt-enable, modem-control, FIFO-control, scratch and divisor values. It routes reads of receive data, interrupt identity, line status and modem status from the datapath inputs. It issues one-cycle strobes that pop the receive queue, push the transmit queue, and clear either FIFO. The datapath derives the baud rate as the 1.8432 MHz reference divided by 16 times the divisor, so a divisor of 115200 / baud gives the wanted rate. Line-control value 0x03 selects 8 data bits, no parity and 1 stop bit.

A host programs the rate in four steps. It sets the bank bit, writes the low divisor byte at offset 0, writes the high byte at offset 1, and then clears the bank bit.

Top module: `uart_regbank`

## Requirements
- R1: After reset, line_ctl, int_en, modem_ctl, fifo_ctl, divisor and rdata are all zero, and no strobe is high.
- R2: A read of offset 0 while line_ctl[7] is 0 returns rxq_data in rdata and raises rxq_pop. Both appear in the cycle after the read strobe, and rxq_pop lasts one cycle.
- R3: A write to offset 0 while line_ctl[7] is 0 raises txq_push for one cycle in the cycle after the write, with txq_data equal to the written byte.
- R4: While line_ctl[7] is 1, offset 0 reads and writes divisor[7:0] and offset 1 reads and writes divisor[15:8]. Neither rxq_pop nor txq_push is issued.
- R5: Offset 3 reads and writes the full 8-bit line_ctl. Bit 7 is the bank select.
- R6: Offset 1 reads and writes int_en while line_ctl[7] is 0. Only bits 3:0 are stored, and bits 7:4 read as 0.
- R7: A write to offset 2 stores fifo_ctl with bits 1 and 2 forced to 0. Written bit 1 pulses fifo_rx_clr and written bit 2 pulses fifo_tx_clr, each for one cycle after the write. A read of offset 2 returns int_id_in.
- R8: Offset 4 reads and writes modem_ctl. Only bits 4:0 are stored, and bits 7:5 read as 0.
- R9: Offset 5 reads line_stat_in and offset 6 reads modem_stat_in. Writes to either offset change no stored value and raise no strobe.
- R10: Offset 7 is a scratch byte that reads back as written and changes no output.
- R11: rdata changes only in the cycle after a read strobe and holds its value otherwise.
- R12: When read and write strobes are both high, the read returns the value from before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Port offset |
| rd_en | input | 1 | Read strobe, one access per high cycle |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rxq_data | input | 8 | Head byte of the receive queue |
| int_id_in | input | 8 | Interrupt identity from the interrupt logic |
| line_stat_in | input | 8 | Line status from the datapath |
| modem_stat_in | input | 8 | Modem status from the pin logic |
| rxq_pop | output | 1 | One-cycle receive pop strobe |
| txq_push | output | 1 | One-cycle transmit push strobe |
| txq_data | output | 8 | Byte for the transmit queue |
| fifo_rx_clr | output | 1 | One-cycle receive FIFO clear |
| fifo_tx_clr | output | 1 | One-cycle transmit FIFO clear |
| line_ctl | output | 8 | Line-control byte, bit 7 is the bank select |
| int_en | output | 8 | Interrupt enables |
| modem_ctl | output | 8 | Modem control outputs |
| fifo_ctl | output | 8 | Stored FIFO control |
| divisor | output | 16 | Baud divisor |

## Verification
A stuck or wrong bank bit sends data-port writes to the divisor instead of the transmit queue. That shows as a missing txq_push and a changed divisor in the cycle after the write. A wrong decode or storage mask shows in the readback, one cycle after the read strobe, as a neighbouring register's byte or as set bits that should read zero. Strobes are checked both in the cycle they must rise and in the following cycle, where they must have fallen. This catches pulses that stretch or that fire from the wrong bank.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
   localparam int unsigned PORT_W = 3;

   typedef enum logic [PORT_W-1:0] {
      PORT_DATA    = 3'd0,
      PORT_IE      = 3'd1,
      PORT_ID      = 3'd2,
      PORT_LINE    = 3'd3,
      PORT_MODEM   = 3'd4,
      PORT_LSTAT   = 3'd5,
      PORT_MSTAT   = 3'd6,
      PORT_SCRATCH = 3'd7
   } port_e;

   typedef enum logic [3:0] {
      SRC_RXQ, SRC_DIV_LO, SRC_DIV_HI, SRC_IE, SRC_ID,
      SRC_LINE, SRC_MODEM, SRC_LSTAT, SRC_MSTAT, SRC_SCRATCH
   } rsrc_e;

   typedef struct packed {
      logic tx_push;
      logic div_lo;
      logic div_hi;
      logic ie;
      logic fifo;
      logic line;
      logic modem;
      logic scratch;
   } wsel_t;
endpackage

// File: rtl/uart_rf_reg.sv
module uart_rf_reg #(
   parameter int unsigned   W    = 8,
   parameter logic [W-1:0]  RST  = '0,
   parameter logic [W-1:0]  KEEP = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W == 0) begin : g_bad_width
         $error("uart_rf_reg: width must be nonzero");
      end
      if ((RST & ~KEEP) != '0) begin : g_bad_reset
         $error("uart_rf_reg: reset value sets bits that are not kept");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= d & KEEP;
   end
endmodule

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
   import uart_rf_pkg::*;
(
   input  logic [PORT_W-1:0] addr,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic              bank_sel,
   output wsel_t             wsel,
   output logic              rd_pop,
   output rsrc_e             rsrc
);
   port_e port;
   assign port = port_e'(addr);

   always_comb begin
      wsel   = '0;
      rd_pop = 1'b0;
      rsrc   = SRC_SCRATCH;
      case (port)
         PORT_DATA: begin
            if (bank_sel) begin
               wsel.div_lo = wr_en;
               rsrc        = SRC_DIV_LO;
            end else begin
               wsel.tx_push = wr_en;
               rd_pop       = rd_en;
               rsrc         = SRC_RXQ;
            end
         end
         PORT_IE: begin
            if (bank_sel) begin
               wsel.div_hi = wr_en;
               rsrc        = SRC_DIV_HI;
            end else begin
               wsel.ie = wr_en;
               rsrc    = SRC_IE;
            end
         end
         PORT_ID: begin
            wsel.fifo = wr_en;
            rsrc      = SRC_ID;
         end
         PORT_LINE: begin
            wsel.line = wr_en;
            rsrc      = SRC_LINE;
         end
         PORT_MODEM: begin
            wsel.modem = wr_en;
            rsrc       = SRC_MODEM;
         end
         PORT_LSTAT:  rsrc = SRC_LSTAT;
         PORT_MSTAT:  rsrc = SRC_MSTAT;
         PORT_SCRATCH: begin
            wsel.scratch = wr_en;
            rsrc         = SRC_SCRATCH;
         end
         default: rsrc = SRC_SCRATCH;
      endcase
   end
endmodule

// File: rtl/uart_rf_rdmux.sv
module uart_rf_rdmux
   import uart_rf_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  rsrc_e             rsrc,
   input  logic [DATA_W-1:0] rxq_data,
   input  logic [DATA_W-1:0] div_lo,
   input  logic [DATA_W-1:0] div_hi,
   input  logic [DATA_W-1:0] int_en,
   input  logic [DATA_W-1:0] int_id,
   input  logic [DATA_W-1:0] line_ctl,
   input  logic [DATA_W-1:0] modem_ctl,
   input  logic [DATA_W-1:0] line_stat,
   input  logic [DATA_W-1:0] modem_stat,
   input  logic [DATA_W-1:0] scratch,
   output logic [DATA_W-1:0] dout
);
   always_comb begin
      case (rsrc)
         SRC_RXQ:     dout = rxq_data;
         SRC_DIV_LO:  dout = div_lo;
         SRC_DIV_HI:  dout = div_hi;
         SRC_IE:      dout = int_en;
         SRC_ID:      dout = int_id;
         SRC_LINE:    dout = line_ctl;
         SRC_MODEM:   dout = modem_ctl;
         SRC_LSTAT:   dout = line_stat;
         SRC_MSTAT:   dout = modem_stat;
         SRC_SCRATCH: dout = scratch;
         default:     dout = '0;
      endcase
   end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
   import uart_rf_pkg::*;
#(
   parameter int unsigned         DATA_W   = 8,
   parameter int unsigned         DIV_W    = 16,
   parameter logic [DIV_W-1:0]    DIV_RST  = '0,
   parameter logic [DATA_W-1:0]   IE_KEEP  = 8'h0F,
   parameter logic [DATA_W-1:0]   MC_KEEP  = 8'h1F,
   parameter logic [DATA_W-1:0]   FC_KEEP  = 8'hF9,
   parameter int unsigned         RXCLR_BIT = 1,
   parameter int unsigned         TXCLR_BIT = 2,
   parameter int unsigned         BANK_BIT  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        addr,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] rxq_data,
   input  logic [DATA_W-1:0] int_id_in,
   input  logic [DATA_W-1:0] line_stat_in,
   input  logic [DATA_W-1:0] modem_stat_in,
   output logic              rxq_pop,
   output logic              txq_push,
   output logic [DATA_W-1:0] txq_data,
   output logic              fifo_rx_clr,
   output logic              fifo_tx_clr,
   output logic [DATA_W-1:0] line_ctl,
   output logic [DATA_W-1:0] int_en,
   output logic [DATA_W-1:0] modem_ctl,
   output logic [DATA_W-1:0] fifo_ctl,
   output logic [DIV_W-1:0]  divisor
);
   localparam int unsigned DIV_BYTES = DIV_W / DATA_W;

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("uart_regbank: register bytes must be 8 bits");
      end
      if (DIV_BYTES != 2 || DIV_W % DATA_W != 0) begin : g_bad_div
         $error("uart_regbank: divisor must span exactly two banked ports");
      end
      if (RXCLR_BIT >= DATA_W || TXCLR_BIT >= DATA_W || BANK_BIT >= DATA_W) begin : g_bad_bit
         $error("uart_regbank: control bit position out of range");
      end
      if (FC_KEEP[RXCLR_BIT] || FC_KEEP[TXCLR_BIT]) begin : g_bad_fc
         $error("uart_regbank: FIFO clear bits must be self-clearing");
      end
   endgenerate

   logic        bank_sel;
   wsel_t       wsel;
   logic        rd_pop;
   rsrc_e       rsrc;
   logic [DATA_W-1:0] scratch;
   logic [DATA_W-1:0] rd_mux;
   logic [DIV_BYTES-1:0] div_we;

   assign bank_sel = line_ctl[BANK_BIT];

   uart_rf_decode u_dec (
      .addr     (addr),
      .rd_en    (rd_en),
      .wr_en    (wr_en),
      .bank_sel (bank_sel),
      .wsel     (wsel),
      .rd_pop   (rd_pop),
      .rsrc     (rsrc)
   );

   uart_rf_reg #(.W(DATA_W), .RST('0), .KEEP('1)) u_line (
      .clk(clk), .rst_n(rst_n), .we(wsel.line), .d(wdata), .q(line_ctl));

   uart_rf_reg #(.W(DATA_W), .RST('0), .KEEP(IE_KEEP)) u_ie (
      .clk(clk), .rst_n(rst_n), .we(wsel.ie), .d(wdata), .q(int_en));

   uart_rf_reg #(.W(DATA_W), .RST('0), .KEEP(MC_KEEP)) u_modem (
      .clk(clk), .rst_n(rst_n), .we(wsel.modem), .d(wdata), .q(modem_ctl));

   uart_rf_reg #(.W(DATA_W), .RST('0), .KEEP(FC_KEEP)) u_fifo (
      .clk(clk), .rst_n(rst_n), .we(wsel.fifo), .d(wdata), .q(fifo_ctl));

   uart_rf_reg #(.W(DATA_W), .RST('0), .KEEP('1)) u_scratch (
      .clk(clk), .rst_n(rst_n), .we(wsel.scratch), .d(wdata), .q(scratch));

   assign div_we = {wsel.div_hi, wsel.div_lo};

   genvar b;
   generate
      for (b = 0; b < DIV_BYTES; b++) begin : g_div
         uart_rf_reg #(
            .W    (DATA_W),
            .RST  (DIV_RST[b*DATA_W +: DATA_W]),
            .KEEP ('1)
         ) u_byte (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (div_we[b]),
            .d     (wdata),
            .q     (divisor[b*DATA_W +: DATA_W])
         );
      end
   endgenerate

   uart_rf_rdmux #(.DATA_W(DATA_W)) u_rdmux (
      .rsrc       (rsrc),
      .rxq_data   (rxq_data),
      .div_lo     (divisor[DATA_W-1:0]),
      .div_hi     (divisor[DIV_W-1:DATA_W]),
      .int_en     (int_en),
      .int_id     (int_id_in),
      .line_ctl   (line_ctl),
      .modem_ctl  (modem_ctl),
      .line_stat  (line_stat_in),
      .modem_stat (modem_stat_in),
      .scratch    (scratch),
      .dout       (rd_mux)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxq_pop     <= 1'b0;
         txq_push    <= 1'b0;
         txq_data    <= '0;
         fifo_rx_clr <= 1'b0;
         fifo_tx_clr <= 1'b0;
      end else begin
         rxq_pop     <= rd_pop;
         txq_push    <= wsel.tx_push;
         fifo_rx_clr <= wsel.fifo & wdata[RXCLR_BIT];
         fifo_tx_clr <= wsel.fifo & wdata[TXCLR_BIT];
         if (wsel.tx_push) txq_data <= wdata;
      end
   end

   // R2
   pop_from_data_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rxq_pop |-> ($past(rd_en) && $past(addr) == 3'd0 && !$past(line_ctl[BANK_BIT])));

   // R3
   push_from_data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txq_push |-> ($past(wr_en) && $past(addr) == 3'd0 && !$past(line_ctl[BANK_BIT])));

   // R4
   no_strobe_in_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_en || wr_en) && addr == 3'd0 && line_ctl[BANK_BIT]) |=> (!rxq_pop && !txq_push));

   // R7
   fifo_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_rx_clr || fifo_tx_clr) |-> ($past(wr_en) && $past(addr) == 3'd2));

   // R9
   ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (addr == 3'd5 || addr == 3'd6)) |=>
         ($stable(line_ctl) && $stable(int_en) && $stable(modem_ctl) &&
          $stable(fifo_ctl) && $stable(divisor) && !txq_push));

   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

// File: tb/tb_uart_regbank.sv
module tb_uart_regbank;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  addr = '0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [7:0]  rxq_data = 8'hA5;
   logic [7:0]  int_id_in = 8'hC1;
   logic [7:0]  line_stat_in = 8'h60;
   logic [7:0]  modem_stat_in = 8'hB0;
   logic        rxq_pop, txq_push, fifo_rx_clr, fifo_tx_clr;
   logic [7:0]  txq_data, line_ctl, int_en, modem_ctl, fifo_ctl;
   logic [15:0] divisor;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_regbank dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
      .wdata(wdata), .rdata(rdata), .rxq_data(rxq_data), .int_id_in(int_id_in),
      .line_stat_in(line_stat_in), .modem_stat_in(modem_stat_in),
      .rxq_pop(rxq_pop), .txq_push(txq_push), .txq_data(txq_data),
      .fifo_rx_clr(fifo_rx_clr), .fifo_tx_clr(fifo_tx_clr),
      .line_ctl(line_ctl), .int_en(int_en), .modem_ctl(modem_ctl),
      .fifo_ctl(fifo_ctl), .divisor(divisor)
   );

   // entry: {req[23:20], is_write[19], addr[18:16], wdata[15:8], expected[7:0]}
   localparam logic [23:0] VEC [NV] = '{
      {4'd5,  1'b1, 3'd3, 8'h83, 8'h00},  // R5 set bank bit, 8N1
      {4'd4,  1'b1, 3'd0, 8'h0C, 8'h00},  // R4 divisor low
      {4'd4,  1'b1, 3'd1, 8'h00, 8'h00},  // R4 divisor high
      {4'd4,  1'b0, 3'd0, 8'h00, 8'h0C},  // R4
      {4'd4,  1'b0, 3'd1, 8'h00, 8'h00},  // R4
      {4'd5,  1'b0, 3'd3, 8'h00, 8'h83},  // R5
      {4'd5,  1'b1, 3'd3, 8'h03, 8'h00},  // R5 clear bank bit
      {4'd5,  1'b0, 3'd3, 8'h00, 8'h03},  // R5
      {4'd6,  1'b1, 3'd1, 8'hFF, 8'h00},  // R6
      {4'd6,  1'b0, 3'd1, 8'h00, 8'h0F},  // R6 upper bits read zero
      {4'd8,  1'b1, 3'd4, 8'hFF, 8'h00},  // R8
      {4'd8,  1'b0, 3'd4, 8'h00, 8'h1F},  // R8 upper bits read zero
      {4'd10, 1'b1, 3'd7, 8'h5A, 8'h00},  // R10
      {4'd10, 1'b0, 3'd7, 8'h00, 8'h5A},  // R10
      {4'd7,  1'b0, 3'd2, 8'h00, 8'hC1},  // R7 read returns interrupt id
      {4'd9,  1'b0, 3'd5, 8'h00, 8'h60},  // R9 line status
      {4'd9,  1'b0, 3'd6, 8'h00, 8'hB0},  // R9 modem status
      {4'd2,  1'b0, 3'd0, 8'h00, 8'hA5}   // R2 receive data
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] got;
      logic [7:0] held;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 line_ctl", {8'h0, line_ctl}, 16'h0);
      check("R1 int_en", {8'h0, int_en}, 16'h0);
      check("R1 modem_ctl", {8'h0, modem_ctl}, 16'h0);
      check("R1 fifo_ctl", {8'h0, fifo_ctl}, 16'h0);
      check("R1 divisor", divisor, 16'h0);
      check("R1 rdata", {8'h0, rdata}, 16'h0);
      check("R1 strobes", {12'h0, rxq_pop, txq_push, fifo_rx_clr, fifo_tx_clr}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [23:0] v;
         v = VEC[i];
         if (v[19]) do_write(v[18:16], v[15:8]);
         else begin
            do_read(v[18:16], got);
            check($sformatf("R%0d vector %0d", v[23:20], i), {8'h0, got}, {8'h0, v[7:0]});
         end
      end
      check("R4 divisor port", divisor, 16'h000C);

      // R2 pop lasts one cycle
      do_read(3'd0, got);
      check("R2 pop high", {15'h0, rxq_pop}, 16'h1);
      @(negedge clk);
      check("R2 pop low", {15'h0, rxq_pop}, 16'h0);

      // R3 push with data
      do_write(3'd0, 8'h3C);
      check("R3 push high", {15'h0, txq_push}, 16'h1);
      check("R3 push data", {8'h0, txq_data}, 16'h003C);
      @(negedge clk);
      check("R3 push low", {15'h0, txq_push}, 16'h0);

      // R4 banked data port: no push, no pop
      do_write(3'd3, 8'h80);
      do_write(3'd0, 8'h77);
      check("R4 no push in bank", {15'h0, txq_push}, 16'h0);
      check("R4 divisor low written", divisor, 16'h0077);
      do_read(3'd0, got);
      check("R4 banked read", {8'h0, got}, 16'h0077);
      check("R4 no pop in bank", {15'h0, rxq_pop}, 16'h0);
      do_write(3'd3, 8'h03);

      // R9 writes to status offsets ignored
      do_write(3'd5, 8'hFF);
      check("R9 no strobe lstat", {15'h0, txq_push}, 16'h0);
      do_write(3'd6, 8'hFF);
      check("R9 line_ctl kept", {8'h0, line_ctl}, 16'h0003);
      check("R9 int_en kept", {8'h0, int_en}, 16'h000F);
      check("R9 modem_ctl kept", {8'h0, modem_ctl}, 16'h001F);
      check("R9 divisor kept", divisor, 16'h0077);
      do_read(3'd7, got);
      check("R9 scratch kept", {8'h0, got}, 16'h005A);

      // R10 scratch write leaves outputs alone
      do_write(3'd7, 8'hEE);
      check("R10 no strobe", {12'h0, rxq_pop, txq_push, fifo_rx_clr, fifo_tx_clr}, 16'h0);
      check("R10 line_ctl", {8'h0, line_ctl}, 16'h0003);
      do_read(3'd7, got);
      check("R10 readback", {8'h0, got}, 16'h00EE);

      // R7 FIFO control
      do_write(3'd2, 8'hC7);
      check("R7 clear pulses", {14'h0, fifo_rx_clr, fifo_tx_clr}, 16'h0003);
      check("R7 fifo_ctl stored", {8'h0, fifo_ctl}, 16'h00C1);
      @(negedge clk);
      check("R7 clear pulses end", {14'h0, fifo_rx_clr, fifo_tx_clr}, 16'h0);
      do_write(3'd2, 8'h02);
      check("R7 rx clear only", {14'h0, fifo_rx_clr, fifo_tx_clr}, 16'h0002);
      do_read(3'd2, got);
      check("R7 read gives id", {8'h0, got}, 16'h00C1);

      // R11 rdata holds without a read
      do_read(3'd5, held);
      line_stat_in = 8'h01;
      repeat (3) @(negedge clk);
      check("R11 rdata held", {8'h0, rdata}, {8'h0, held});

      // R12 read and write in the same cycle
      @(negedge clk);
      addr = 3'd3; wdata = 8'h07; rd_en = 1'b1; wr_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      check("R12 read sees old", {8'h0, rdata}, 16'h0003);
      check("R12 write applied", {8'h0, line_ctl}, 16'h0007);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule